// File: doc/BRIEF.md
# Host-to-Local Address Window Translator

This block sits between a host firmware-space request port and a local bus. It holds one programmable window. Each host request carries a 32-bit address. The block decides whether the address falls inside the window. On a hit it issues the matching local address one clock later, with a valid strobe. A request that misses, or that arrives while host cycles are not enabled, is reported as unclaimed on the same later cycle. Windows work at 64 KiB granularity, so only the upper half of the address is looked at. The lower half passes straight through.

The window is described by two registers. The map register holds the upper half of the local base in bits 31:16 and the upper half of the host base in bits 15:0. The mask register holds a replace mask in bits 31:16 and a keep mask in bits 15:0. For a window of size S, software writes ~(S-1) into the replace half and (S>>16)-1 into the keep half. An enable register gates host cycles. A control/status register carries one mode bit and a set of write-one-to-clear status flags. The status flags are set by external event inputs and by unclaimed requests.

Top module: `hwin_xlate`

## Requirements
- R1: After reset, all four registers read as zero, and xl_valid_o, unclaimed_o and fw_alt_mode_o are low.
- R2: A request hits when (req_addr_i[31:16] XOR map[15:0]) AND NOT mask[15:0] is zero, where map is the map register at index 0 and mask is the mask register at index 1.
- R3: On a hit, xl_addr_o[31:16] equals (map[31:16] AND mask[31:16]) OR (req_addr_i[31:16] AND mask[15:0]), even when the local base is not aligned to the window.
- R4: On a hit, xl_addr_o[15:0] equals req_addr_i[15:0].
- R5: xl_valid_o and xl_addr_o become valid on the clock edge that samples req_valid_i. They last for exactly one cycle per request.
- R6: A request is answered only when bit 10 and bit 8 of the enable register (index 2) are both 1. With either bit clear, every request is unclaimed.
- R7: Every request produces, one cycle later, exactly one of xl_valid_o or unclaimed_o. The two are never high together.
- R8: An unclaimed request sets status bit 0 of the control/status register (index 3).
- R9: Bit 17 of the control/status register takes the value written to it on every write to index 3. It drives fw_alt_mode_o. stat_set_i[17] has no effect on it.
- R10: On a write to index 3, every status bit other than 17 whose written bit is 1 clears, and every status bit whose written bit is 0 keeps its value.
- R11: A 1 on stat_set_i[k], for k other than 17, sets status bit k at the next edge. A set wins over a same-cycle write-one clear of the same bit.
- R12: The registers at indices 0, 1 and 2 read back what was last written to them. Index 3 reads the status bits with the mode bit in position 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 2 | Register index (0 map, 1 mask, 2 enable, 3 control/status) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the register selected by reg_idx_i |
| stat_set_i | input | 32 | Per-bit status set events |
| req_valid_i | input | 1 | Host request strobe |
| req_addr_i | input | 32 | Host firmware-space address |
| xl_valid_o | output | 1 | Translated address valid |
| xl_addr_o | output | 32 | Translated local address |
| unclaimed_o | output | 1 | Request not answered by the window |
| fw_alt_mode_o | output | 1 | Alternate firmware-to-local mode select |

## Verification
Two paths can touch the same status bit in one clock edge: a hardware set and a software write-one clear. A third source, the unclaimed-request event on bit 0, competes with both. The bench drives stat_set_i and a write to index 3 in the same cycle, with both aimed at one bit. It then reads the register back and expects that bit to stay set while a neighbouring bit cleared by the same write goes to zero. A second case writes only the mode bit while status flags are pending. This case checks that the mode toggles and the flags stay as they were.

// File: rtl/hwin_pkg.sv
package hwin_pkg;

  localparam int REG_IDX_W = 2;

  typedef enum logic [REG_IDX_W-1:0] {
    RIDX_MAP  = 2'd0,
    RIDX_MASK = 2'd1,
    RIDX_ENA  = 2'd2,
    RIDX_CTL  = 2'd3
  } reg_idx_e;

endpackage

// File: rtl/hwin_regfile.sv
module hwin_regfile
  import hwin_pkg::*;
#(
  parameter int DW        = 32,
  parameter int MODE_BIT  = 17,
  parameter int UNCL_BIT  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [REG_IDX_W-1:0] idx,
  input  logic [DW-1:0]        wdata,
  input  logic [DW-1:0]        stat_set,
  input  logic                 uncl_evt,
  output logic [DW-1:0]        map_q,
  output logic [DW-1:0]        mask_q,
  output logic [DW-1:0]        en_q,
  output logic                 mode_q,
  output logic [DW-1:0]        stat_q,
  output logic [DW-1:0]        rdata
);

  localparam logic [DW-1:0] MODE_MASK = DW'(1) << MODE_BIT;
  localparam logic [DW-1:0] UNCL_MASK = DW'(1) << UNCL_BIT;

  logic          wr_map, wr_mask, wr_en, wr_ctl;
  logic [DW-1:0] set_vec;
  logic [DW-1:0] stat_nxt;

  assign wr_map  = we && (reg_idx_e'(idx) == RIDX_MAP);
  assign wr_mask = we && (reg_idx_e'(idx) == RIDX_MASK);
  assign wr_en   = we && (reg_idx_e'(idx) == RIDX_ENA);
  assign wr_ctl  = we && (reg_idx_e'(idx) == RIDX_CTL);

  assign set_vec = (stat_set | (uncl_evt ? UNCL_MASK : '0)) & ~MODE_MASK;

  // Software clear goes first, then the hardware set, so that a set wins.
  always_comb begin
    stat_nxt = stat_q;
    if (wr_ctl) stat_nxt = stat_nxt & ~wdata;
    stat_nxt = (stat_nxt | set_vec) & ~MODE_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= '0;
      mask_q <= '0;
      en_q   <= '0;
      mode_q <= 1'b0;
      stat_q <= '0;
    end else begin
      if (wr_map)  map_q  <= wdata;
      if (wr_mask) mask_q <= wdata;
      if (wr_en)   en_q   <= wdata;
      if (wr_ctl)  mode_q <= wdata[MODE_BIT];
      stat_q <= stat_nxt;
    end
  end

  always_comb begin
    unique case (reg_idx_e'(idx))
      RIDX_MAP:  rdata = map_q;
      RIDX_MASK: rdata = mask_q;
      RIDX_ENA:  rdata = en_q;
      default:   rdata = stat_q | (mode_q ? MODE_MASK : '0);
    endcase
  end

endmodule

// File: rtl/hwin_window.sv
module hwin_window #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] map_reg,
  input  logic [ADDR_W-1:0] mask_reg,
  output logic              hit,
  output logic [ADDR_W-1:0] xl_addr
);

  localparam int HI_W = ADDR_W / 2;
  localparam int LO_W = ADDR_W - HI_W;

  function automatic logic win_hit(
    input logic [HI_W-1:0] req_hi,
    input logic [HI_W-1:0] host_base,
    input logic [HI_W-1:0] keep
  );
    return ((req_hi ^ host_base) & ~keep) == '0;
  endfunction

  function automatic logic [HI_W-1:0] win_xlate(
    input logic [HI_W-1:0] req_hi,
    input logic [HI_W-1:0] local_base,
    input logic [HI_W-1:0] repl,
    input logic [HI_W-1:0] keep
  );
    return (local_base & repl) | (req_hi & keep);
  endfunction

  logic [HI_W-1:0] req_hi, local_base, host_base, repl, keep;

  assign req_hi     = req_addr[ADDR_W-1:LO_W];
  assign local_base = map_reg[ADDR_W-1:HI_W];
  assign host_base  = map_reg[HI_W-1:0];
  assign repl       = mask_reg[ADDR_W-1:HI_W];
  assign keep       = mask_reg[HI_W-1:0];

  assign hit     = win_hit(req_hi, host_base, keep);
  assign xl_addr = {win_xlate(req_hi, local_base, repl, keep), req_addr[LO_W-1:0]};

endmodule

// File: rtl/hwin_resp.sv
module hwin_resp #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim,
  input  logic              unclaim,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              xl_valid,
  output logic [ADDR_W-1:0] xl_addr,
  output logic              unclaimed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_valid  <= 1'b0;
      xl_addr   <= '0;
      unclaimed <= 1'b0;
    end else begin
      xl_valid  <= claim;
      unclaimed <= unclaim;
      if (claim) xl_addr <= addr_in;
    end
  end

endmodule

// File: rtl/hwin_xlate.sv
module hwin_xlate
  import hwin_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int FW_EN_BIT = 10,
  parameter int HL_EN_BIT = 8,
  parameter int MODE_BIT  = 17,
  parameter int UNCL_BIT  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we_i,
  input  logic [REG_IDX_W-1:0] reg_idx_i,
  input  logic [ADDR_W-1:0]    reg_wdata_i,
  output logic [ADDR_W-1:0]    reg_rdata_o,
  input  logic [ADDR_W-1:0]    stat_set_i,
  input  logic                 req_valid_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  output logic                 xl_valid_o,
  output logic [ADDR_W-1:0]    xl_addr_o,
  output logic                 unclaimed_o,
  output logic                 fw_alt_mode_o
);

  logic [ADDR_W-1:0] map_q, mask_q, en_q, stat_q;
  logic [ADDR_W-1:0] xl_comb;
  logic              win_hit;
  logic              cyc_en;
  logic              claim_w;
  logic              unclaim_w;

  hwin_regfile #(
    .DW       (ADDR_W),
    .MODE_BIT (MODE_BIT),
    .UNCL_BIT (UNCL_BIT)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we_i),
    .idx      (reg_idx_i),
    .wdata    (reg_wdata_i),
    .stat_set (stat_set_i),
    .uncl_evt (unclaim_w),
    .map_q    (map_q),
    .mask_q   (mask_q),
    .en_q     (en_q),
    .mode_q   (fw_alt_mode_o),
    .stat_q   (stat_q),
    .rdata    (reg_rdata_o)
  );

  hwin_window #(.ADDR_W(ADDR_W)) win_i (
    .req_addr (req_addr_i),
    .map_reg  (map_q),
    .mask_reg (mask_q),
    .hit      (win_hit),
    .xl_addr  (xl_comb)
  );

  assign cyc_en    = en_q[FW_EN_BIT] & en_q[HL_EN_BIT];
  assign claim_w   = req_valid_i & cyc_en & win_hit;
  assign unclaim_w = req_valid_i & ~claim_w;

  hwin_resp #(.ADDR_W(ADDR_W)) resp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .claim     (claim_w),
    .unclaim   (unclaim_w),
    .addr_in   (xl_comb),
    .xl_valid  (xl_valid_o),
    .xl_addr   (xl_addr_o),
    .unclaimed (unclaimed_o)
  );

endmodule

// File: rtl/hwin_xlate_chk.sv
module hwin_xlate_chk #(
  parameter int DW       = 32,
  parameter int MODE_BIT = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid_i,
  input logic          xl_valid_o,
  input logic          unclaimed_o,
  input logic          cyc_en,
  input logic [DW-1:0] stat_set_i,
  input logic [DW-1:0] stat_q,
  input logic          reg_we_i,
  input logic [1:0]    reg_idx_i,
  input logic          fw_alt_mode_o
);

  localparam logic [DW-1:0] MODE_MASK = DW'(1) << MODE_BIT;

  // R7
  resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_valid_o && unclaimed_o));

  // R5
  resp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid_o || unclaimed_o) |-> $past(req_valid_i));

  // R6
  resp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid_o |-> $past(cyc_en));

  // R7
  req_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(req_valid_i)) |-> (xl_valid_o || unclaimed_o));

  // R11
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((($past(stat_set_i) & ~MODE_MASK) & ~stat_q) == '0));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we_i && (reg_idx_i == 2'd3)) |-> $stable(fw_alt_mode_o));

endmodule

bind hwin_xlate hwin_xlate_chk #(.DW(ADDR_W), .MODE_BIT(MODE_BIT)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid_i   (req_valid_i),
  .xl_valid_o    (xl_valid_o),
  .unclaimed_o   (unclaimed_o),
  .cyc_en        (cyc_en),
  .stat_set_i    (stat_set_i),
  .stat_q        (stat_q),
  .reg_we_i      (reg_we_i),
  .reg_idx_i     (reg_idx_i),
  .fw_alt_mode_o (fw_alt_mode_o)
);

// File: tb/hwin_xlate_tb_top.sv
module hwin_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_idx_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [31:0] stat_set_i = '0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        xl_valid_o;
  logic [31:0] xl_addr_o;
  logic        unclaimed_o;
  logic        fw_alt_mode_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hwin_xlate dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_we_i(reg_we_i), .reg_idx_i(reg_idx_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .stat_set_i(stat_set_i),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .xl_valid_o(xl_valid_o), .xl_addr_o(xl_addr_o),
    .unclaimed_o(unclaimed_o), .fw_alt_mode_o(fw_alt_mode_o)
  );

  // {size, host base, local base, request, expect hit}
  localparam int NVEC = 11;
  localparam logic [128:0] VEC [NVEC] = '{
    {32'h0001_0000, 32'h0FFF_0000, 32'h9876_0000, 32'h0FFF_1234, 1'b1},
    {32'h0001_0000, 32'h0FFF_0000, 32'h9876_0000, 32'h0FFE_FFFF, 1'b0},
    {32'h0001_0000, 32'h0FFF_0000, 32'h9876_0000, 32'h1000_0000, 1'b0},
    {32'h0010_0000, 32'h0FF0_0000, 32'h9E50_0000, 32'h0FF0_0000, 1'b1},
    {32'h0010_0000, 32'h0FF0_0000, 32'h9E50_0000, 32'h0FFF_FFFF, 1'b1},
    {32'h0010_0000, 32'h0FF0_0000, 32'h9E50_0000, 32'h0FEF_FFFF, 1'b0},
    {32'h0010_0000, 32'h0FF0_0000, 32'h9E50_0000, 32'h1000_0000, 1'b0},
    {32'h0200_0000, 32'h0C00_0000, 32'hB800_0000, 32'h0DFF_FFFC, 1'b1},
    {32'h0200_0000, 32'h0C00_0000, 32'hB800_0000, 32'h0E00_0000, 1'b0},
    {32'h0200_0000, 32'h0C00_0000, 32'hB800_0000, 32'h0BFF_FFFF, 1'b0},
    {32'h0200_0000, 32'h0C00_0000, 32'hB800_0000, 32'h0D23_4567, 1'b1}
  };

  localparam logic [31:0] EN_BOTH = 32'h0000_0500;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] data);
    @(negedge clk);
    reg_we_i = 1'b1; reg_idx_i = idx; reg_wdata_i = data;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] data);
    @(negedge clk);
    reg_idx_i = idx;
    #1 data = reg_rdata_o;
  endtask

  // Issues one request; returns the outputs of the following cycle.
  task automatic req(input logic [31:0] a, output logic v, output logic u, output logic [31:0] xa);
    @(negedge clk);
    req_valid_i = 1'b1; req_addr_i = a;
    @(negedge clk);
    req_valid_i = 1'b0;
    v = xl_valid_o; u = unclaimed_o; xa = xl_addr_o;
  endtask

  task automatic program_win(input logic [31:0] sz, input logic [31:0] hb, input logic [31:0] lb);
    logic [31:0] repl_full;
    logic [15:0] keep;
    repl_full = ~(sz - 32'd1);
    keep = 16'((sz >> 16) - 32'd1);
    wr(2'd0, {lb[31:16], hb[31:16]});
    wr(2'd1, {repl_full[31:16], keep});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, xa;
    logic v, u;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), r);
      check("R1 register reset", r, 32'h0);
    end
    check("R1 xl_valid reset", {31'h0, xl_valid_o}, 32'h0);
    check("R1 unclaimed reset", {31'h0, unclaimed_o}, 32'h0);
    check("R1 mode reset", {31'h0, fw_alt_mode_o}, 32'h0);

    // R6/R7 disabled request is unclaimed; R8 status bit 0 set
    req(32'h0FFF_1234, v, u, xa);
    check("R6 disabled no valid", {31'h0, v}, 32'h0);
    check("R7 disabled unclaimed", {31'h0, u}, 32'h1);
    rd(2'd3, r);
    check("R8 unclaimed sets status bit 0", r, 32'h1);

    program_win(32'h0001_0000, 32'h0FFF_0000, 32'h9876_0000);
    wr(2'd2, 32'h0000_0400);
    req(32'h0FFF_1234, v, u, xa);
    check("R6 only bit 10 unclaimed", {30'h0, v, u}, 32'h1);
    wr(2'd2, 32'h0000_0100);
    req(32'h0FFF_1234, v, u, xa);
    check("R6 only bit 8 unclaimed", {30'h0, v, u}, 32'h1);
    wr(2'd2, EN_BOTH);

    // R12 readback
    rd(2'd0, r); check("R12 map readback", r, 32'h9876_0FFF);
    rd(2'd1, r); check("R12 mask readback", r, 32'hFFFF_0000);
    rd(2'd2, r); check("R12 enable readback", r, EN_BOTH);

    // R2/R3/R4/R5 vector walk
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] sz, hb, lb, ra, exp_a;
      logic hit;
      {sz, hb, lb, ra, hit} = VEC[i];
      program_win(sz, hb, lb);
      req(ra, v, u, xa);
      check("R2 hit decision", {30'h0, v, u}, hit ? 32'h2 : 32'h1);
      if (hit) begin
        exp_a = lb + (ra - hb);
        check("R3 R4 translated address", xa, exp_a);
      end
      @(negedge clk);
      check("R5 single cycle response", {30'h0, xl_valid_o, unclaimed_o}, 32'h0);
    end

    // R3 unaligned local base: only replace-masked bits of the base are used
    wr(2'd0, 32'h1234_0FF0);
    wr(2'd1, 32'hFFF0_000F);
    req(32'h0FF5_ABCD, v, u, xa);
    check("R3 unaligned base hit", {31'h0, v}, 32'h1);
    check("R3 unaligned base address", xa, 32'h1235_ABCD);

    // R10 clear all status, mode 0
    wr(2'd3, 32'hFFFD_FFFF);
    rd(2'd3, r); check("R10 clear all", r, 32'h0);

    // R11 set events; R9 set input bit 17 ignored
    @(negedge clk); stat_set_i = 32'h0002_0F10;
    @(negedge clk); stat_set_i = '0;
    rd(2'd3, r); check("R11 status set", r, 32'h0000_0F10);
    check("R9 set input cannot change mode", {31'h0, fw_alt_mode_o}, 32'h0);

    // R9/R10 writing only the mode bit keeps flags
    wr(2'd3, 32'h0002_0000);
    rd(2'd3, r); check("R10 mode-only write keeps flags", r, 32'h0002_0F10);
    check("R9 mode set", {31'h0, fw_alt_mode_o}, 32'h1);

    wr(2'd3, 32'h0000_0100);
    rd(2'd3, r); check("R10 write one clears bit 8", r, 32'h0000_0E10);
    check("R9 mode follows write", {31'h0, fw_alt_mode_o}, 32'h0);

    // R11 set and clear same cycle
    @(negedge clk);
    stat_set_i = 32'h0000_0100;
    reg_we_i = 1'b1; reg_idx_i = 2'd3; reg_wdata_i = 32'h0000_0110;
    @(negedge clk);
    stat_set_i = '0; reg_we_i = 1'b0;
    rd(2'd3, r); check("R11 set wins over clear", r, 32'h0000_0F00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule